// File: doc/BRIEF.md
# Secure OTP Region Overlay Controller

This block fronts the one-time-programmable secure space of a parallel NOR flash. The space holds four 256-word regions. When a secure-entry command names a sector, word accesses to the lowest 1024 word offsets of that sector go to the OTP store and no longer reach the main array. Each region is guarded by its own bit in a 16-bit lock word. Region 0 is locked from the start. Both the OTP cells and the lock bits program only from 1 to 0.

Accesses use one word-addressed bus: address, write data, a write strobe and a read strobe. The address is the sector number concatenated above the word offset. A command strobe with a 2-bit opcode moves the block between three views: the array view, the secure view and the lock-word view. In the array view the bus passes through to the main array. A rejected OTP write raises a one-cycle program-error flag. Read data is registered. It appears the cycle after the read strobe and holds until the next read.

Top module: `otp_overlay_ctrl`

## Requirements
- R1: After synchronous reset, `rdata` is 0x0000, `prog_err` is 0 and the block is in the array view. In the array view, `arr_rd`, `arr_wr`, `arr_addr` and `arr_wdata` follow the bus, and a read returns `arr_rdata` on `rdata` one cycle later.
- R2: Opcode 2'b01 with `cmd_valid` selects the secure view on sector `cmd_sector`. There, word offset o < 0x400 of that sector maps to OTP word o, in region o[9:8].
- R3: In the secure view, reads of any other sector, or of offsets of 0x400 and above, return 0xFFFF. Writes to those addresses change nothing and raise no error. `arr_rd` and `arr_wr` stay low in the secure and lock views.
- R4: Erased OTP words read 0xFFFF. A write to an unlocked region stores the old word AND the written data.
- R5: A write to a locked region leaves the word unchanged and sets `prog_err` for exactly the one cycle after the write. Region 0 is locked from the start.
- R6: Opcode 2'b10 selects the lock view, where every read returns the lock word. The initial lock word is 0xFEFE. Lock bit positions: region 0 at bit 0, region 1 at bit 6, region 2 at bit 9, region 3 at bit 10. Bit 1 is the persistent-mode lock, bit 2 the password-mode lock and bit 11 the region-3 password lock.
- R7: A write in the lock view ANDs the data into bits {11,10,9,6,2,1,0} only. Reserved bits always read as 15:12=1111, 8=0, 7=1 and 5:3=111.
- R8: Lock bits can be cleared in separate writes. Once a region's bit is 0, writes to that region are rejected as in R5, while other unlocked regions still program.
- R9: Lock bits and OTP contents keep their values through reset. A lock bit at 0 never returns to 1.
- R10: Opcode 2'b00 returns to the array view, where accesses reach the main array again.
- R11: `rdata` changes only in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 exit, 01 secure entry, 10 lock-view entry |
| cmd_sector | input | SECT_W | Sector for secure entry |
| addr | input | SECT_W+OFS_W | Word address {sector, offset} |
| wdata | input | 16 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| prog_err | output | 1 | One-cycle rejected-program pulse |
| arr_addr | output | SECT_W+OFS_W | Main array address |
| arr_wdata | output | 16 | Main array write data |
| arr_wr | output | 1 | Main array write strobe |
| arr_rd | output | 1 | Main array read strobe |
| arr_rdata | input | 16 | Main array read data |

## Verification
On every cycle, the assertions check four things. Lock bits never rise. An OTP cell never gains a 1 bit. Any error pulse follows a secure-view write. The read data holds without a read strobe, and a miss in the secure view yields the filler word. Only the directed scenarios can show the rest. These are which sector the overlay lands on, the region boundaries, and region 0 being locked from the start. They also cover the masking of reserved lock bits and the survival of locks and contents across a reset.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_SECURE  = 2'd1,
    MODE_LOCKREG = 2'd2
  } mode_e;

  localparam logic [1:0] OP_EXIT   = 2'b00;
  localparam logic [1:0] OP_SECURE = 2'b01;
  localparam logic [1:0] OP_LOCK   = 2'b10;

  localparam int WORD_W      = 16;
  localparam int NUM_REGIONS = 4;

  // programmable lock bits: 11,10,9,6,2,1,0
  localparam logic [WORD_W-1:0] LOCK_PROG_MASK = 16'h0E47;
  // reserved bits as they always read
  localparam logic [WORD_W-1:0] LOCK_FIXED     = 16'hF0B8;
  // initial programmable part: region 0 locked, all else open
  localparam logic [WORD_W-1:0] LOCK_INIT      = 16'h0E46;

  function automatic int region_lock_pos(input int r);
    case (r)
      0:       return 0;
      1:       return 6;
      2:       return 9;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map #(
  parameter int SECT_W    = 4,
  parameter int OFS_W     = 16,
  parameter int REGIONS   = 4,
  parameter int REG_WORDS = 256,
  localparam int ADDR_W   = SECT_W + OFS_W,
  localparam int IDX_W    = $clog2(REGIONS * REG_WORDS),
  localparam int RG_W     = $clog2(REGIONS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SECT_W-1:0] sel_sector,
  output logic              hit,
  output logic [RG_W-1:0]   region,
  output logic [IDX_W-1:0]  idx
);
  logic [SECT_W-1:0] a_sec;
  logic [OFS_W-1:0]  a_ofs;

  assign a_sec  = addr[ADDR_W-1:OFS_W];
  assign a_ofs  = addr[OFS_W-1:0];
  assign hit    = (a_sec == sel_sector) && (a_ofs[OFS_W-1:IDX_W] == '0);
  assign idx    = a_ofs[IDX_W-1:0];
  assign region = a_ofs[IDX_W-1 -: RG_W];
endmodule

// File: rtl/otp_lock_reg.sv
module otp_lock_reg
  import otp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   prog_en,
  input  logic [WORD_W-1:0]      prog_data,
  output logic [WORD_W-1:0]      lock_word,
  output logic [NUM_REGIONS-1:0] region_open
);
  // nonvolatile: deliberately not cleared by rst
  logic [WORD_W-1:0] prog_q = LOCK_INIT;

  always_ff @(posedge clk) begin
    if (prog_en)
      prog_q <= prog_q & (prog_data | ~LOCK_PROG_MASK);
  end

  assign lock_word = (prog_q & LOCK_PROG_MASK) | (LOCK_FIXED & ~LOCK_PROG_MASK);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_open
    assign region_open[r] = lock_word[region_lock_pos(r)];
  end

  assert_lock_never_rises_R9: assert property (@(posedge clk) disable iff (rst)
    ((lock_word & ~$past(lock_word)) == '0));
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH] = '{default: '1};
  logic [DW-1:0] cell_old;

  assign cell_old = mem[widx];
  assign rdata    = mem[ridx];

  always_ff @(posedge clk) begin
    if (we)
      mem[widx] <= cell_old & wdata;
  end

  assert_cell_only_clears_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> ((mem[$past(widx)] | $past(cell_old)) == $past(cell_old)));
endmodule

// File: rtl/otp_overlay_ctrl.sv
module otp_overlay_ctrl
  import otp_pkg::*;
#(
  parameter int SECT_W            = 4,
  parameter int OFS_W             = 16,
  parameter int REG_WORDS         = 256,
  parameter logic [WORD_W-1:0] FILL = 16'hFFFF,
  localparam int ADDR_W           = SECT_W + OFS_W,
  localparam int OTP_WORDS        = NUM_REGIONS * REG_WORDS,
  localparam int IDX_W            = $clog2(OTP_WORDS),
  localparam int RG_W             = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [WORD_W-1:0] rdata,
  output logic              prog_err,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [WORD_W-1:0] arr_wdata,
  output logic              arr_wr,
  output logic              arr_rd,
  input  logic [WORD_W-1:0] arr_rdata
);
  mode_e             mode_q;
  logic [SECT_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_ARRAY;
      sel_q  <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_SECURE: begin
          mode_q <= MODE_SECURE;
          sel_q  <= cmd_sector;
        end
        OP_LOCK:  mode_q <= MODE_LOCKREG;
        default:  mode_q <= MODE_ARRAY;
      endcase
    end
  end

  logic in_arr, in_sec, in_lock;
  assign in_arr  = (mode_q == MODE_ARRAY);
  assign in_sec  = (mode_q == MODE_SECURE);
  assign in_lock = (mode_q == MODE_LOCKREG);

  logic             hit;
  logic [RG_W-1:0]  region;
  logic [IDX_W-1:0] idx;

  otp_addr_map #(
    .SECT_W(SECT_W), .OFS_W(OFS_W), .REGIONS(NUM_REGIONS), .REG_WORDS(REG_WORDS)
  ) u_map (
    .addr(addr), .sel_sector(sel_q), .hit(hit), .region(region), .idx(idx)
  );

  logic [WORD_W-1:0]      lock_word;
  logic [NUM_REGIONS-1:0] region_open;

  otp_lock_reg u_lock (
    .clk(clk), .rst(rst), .prog_en(wr && in_lock), .prog_data(wdata),
    .lock_word(lock_word), .region_open(region_open)
  );

  logic              sec_wr_hit, otp_we, err_d;
  logic [WORD_W-1:0] otp_rdata;

  assign sec_wr_hit = wr && in_sec && hit;
  assign otp_we     = sec_wr_hit && region_open[region];
  assign err_d      = sec_wr_hit && !region_open[region];

  otp_store #(.DW(WORD_W), .DEPTH(OTP_WORDS)) u_store (
    .clk(clk), .rst(rst), .we(otp_we), .widx(idx), .wdata(wdata),
    .ridx(idx), .rdata(otp_rdata)
  );

  assign arr_addr  = addr;
  assign arr_wdata = wdata;
  assign arr_wr    = wr && in_arr;
  assign arr_rd    = rd && in_arr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      prog_err <= 1'b0;
    end else begin
      prog_err <= err_d;
      if (rd) begin
        if (in_arr)       rdata <= arr_rdata;
        else if (in_lock) rdata <= lock_word;
        else if (hit)     rdata <= otp_rdata;
        else              rdata <= FILL;
      end
    end
  end

  assert_err_follows_write_R5: assert property (@(posedge clk) disable iff (rst)
    prog_err |-> ($past(wr) && $past(mode_q == MODE_SECURE)));

  assert_miss_reads_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (rd && in_sec && !hit) |=> (rdata == FILL));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: tb/sim_otp_overlay_ctrl.sv
module sim_otp_overlay_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [3:0]  cmd_sector = '0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic        prog_err;
  logic [19:0] arr_addr;
  logic [15:0] arr_wdata, arr_rdata;
  logic        arr_wr, arr_rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign arr_rdata = arr_addr[15:0] ^ 16'hA5A5;

  otp_overlay_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .prog_err(prog_err), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_wr(arr_wr), .arr_rd(arr_rd),
    .arr_rdata(arr_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] sec);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic [19:0] a, output logic [15:0] d, output logic seen);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 seen = arr_rd;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [15:0] d,
                        output logic err, output logic seen);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1 seen = arr_wr;
    @(negedge clk);
    wr = 1'b0;
    err = prog_err;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 16'h0000);
    chk("R1 reset prog_err", {15'b0, prog_err}, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_array();
    logic [15:0] d; logic s, e;
    bus_rd(20'h30105, d, s);
    chk("R1 array read data", d, 16'h0105 ^ 16'hA5A5);
    chk("R1 array read strobe", {15'b0, s}, 16'h0001);
    bus_wr(20'h20010, 16'h1234, e, s);
    chk("R1 array write strobe", {15'b0, s}, 16'h0001);
    chk("R1 array write no error", {15'b0, e}, 16'h0000);
  endtask

  task automatic t_overlay();
    logic [15:0] d; logic s, e;
    cmd(2'b01, 4'h5);
    bus_rd(20'h50105, d, s);
    chk("R4 erased word", d, 16'hFFFF);
    chk("R3 no array read in secure", {15'b0, s}, 16'h0000);
    bus_wr(20'h50105, 16'h12F0, e, s);
    chk("R3 no array write in secure", {15'b0, s}, 16'h0000);
    chk("R4 open region no error", {15'b0, e}, 16'h0000);
    bus_rd(20'h50105, d, s);
    chk("R4 first program", d, 16'h12F0);
    bus_wr(20'h50105, 16'hFF0F, e, s);
    bus_rd(20'h50105, d, s);
    chk("R4 AND program", d, 16'h1200);
    cmd(2'b01, 4'h3);
    bus_rd(20'h30105, d, s);
    chk("R2 overlay follows new sector", d, 16'h1200);
    bus_rd(20'h50105, d, s);
    chk("R3 other sector filler", d, 16'hFFFF);
    bus_rd(20'h30400, d, s);
    chk("R3 offset 0x400 filler", d, 16'hFFFF);
    bus_wr(20'h30400, 16'h0000, e, s);
    chk("R3 outside write no error", {15'b0, e}, 16'h0000);
  endtask

  task automatic t_region0();
    logic [15:0] d; logic s, e;
    bus_wr(20'h30007, 16'h0000, e, s);
    chk("R5 region0 error pulse", {15'b0, e}, 16'h0001);
    @(negedge clk);
    chk("R5 error lasts one cycle", {15'b0, prog_err}, 16'h0000);
    bus_rd(20'h30007, d, s);
    chk("R5 region0 unchanged", d, 16'hFFFF);
  endtask

  task automatic t_hold();
    logic [15:0] d; logic s, e;
    bus_rd(20'h30105, d, s);
    repeat (2) @(negedge clk);
    chk("R11 hold idle", rdata, 16'h1200);
    bus_wr(20'h30200, 16'h0000, e, s);
    chk("R11 hold across write", rdata, 16'h1200);
  endtask

  task automatic t_lockreg();
    logic [15:0] d; logic s, e;
    cmd(2'b10, 4'h0);
    bus_rd(20'h00000, d, s);
    chk("R6 default lock word", d, 16'hFEFE);
    chk("R3 no array read in lock view", {15'b0, s}, 16'h0000);
    bus_wr(20'h00000, 16'hFFBF, e, s);
    bus_rd(20'h00000, d, s);
    chk("R8 region1 lock cleared", d, 16'hFEBE);
    bus_wr(20'h00000, 16'h0F47, e, s);
    bus_rd(20'h00000, d, s);
    chk("R7 reserved bits ignored", d, 16'hFEBE);
    cmd(2'b01, 4'h3);
    bus_wr(20'h30105, 16'h0000, e, s);
    chk("R8 locked region1 error", {15'b0, e}, 16'h0001);
    bus_rd(20'h30105, d, s);
    chk("R8 region1 unchanged", d, 16'h1200);
    bus_wr(20'h302AA, 16'h0F0F, e, s);
    chk("R8 region2 still open", {15'b0, e}, 16'h0000);
    bus_rd(20'h302AA, d, s);
    chk("R8 region2 programmed", d, 16'h0F0F);
  endtask

  task automatic t_persist();
    logic [15:0] d; logic s;
    t_reset();
    bus_rd(20'h302AA, d, s);
    chk("R1 array view after reset", d, 16'h02AA ^ 16'hA5A5);
    cmd(2'b10, 4'h0);
    bus_rd(20'h00000, d, s);
    chk("R9 lock word kept", d, 16'hFEBE);
    cmd(2'b01, 4'h3);
    bus_rd(20'h302AA, d, s);
    chk("R9 OTP word kept", d, 16'h0F0F);
  endtask

  task automatic t_exit();
    logic [15:0] d; logic s;
    cmd(2'b00, 4'h0);
    bus_rd(20'h302AA, d, s);
    chk("R10 exit restores array data", d, 16'h02AA ^ 16'hA5A5);
    chk("R10 exit restores array strobe", {15'b0, s}, 16'h0001);
  endtask

  task automatic t_lock3();
    logic [15:0] d; logic s, e;
    cmd(2'b10, 4'h0);
    bus_wr(20'h00000, 16'hFBFF, e, s);
    bus_rd(20'h00000, d, s);
    chk("R8 region3 lock cleared", d, 16'hFABE);
    cmd(2'b01, 4'h0);
    bus_wr(20'h003FF, 16'h0000, e, s);
    chk("R8 region3 error", {15'b0, e}, 16'h0001);
    bus_rd(20'h003FF, d, s);
    chk("R8 region3 unchanged", d, 16'hFFFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_array();
    t_overlay();
    t_region0();
    t_hold();
    t_lockreg();
    t_persist();
    t_exit();
    t_lock3();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule